// File: doc/BRIEF.md
# Audio Noise Gate Controller

This block watches a stream of signed audio samples and decides when the input has been quiet for long enough to gate it. It follows the sample level with a peak detector and compares that level against a threshold picked by a 5-bit code. The codes are spaced in steps of about 1.5 dB. Once the level has stayed below the threshold for a set number of samples, the gate closes. A 2-bit type code then picks what the gate does. It can freeze the gain, raise a digital mute, ramp the gain to its minimum, or ramp the gain and then mute.

The block sits beside a sample path and a gain stage. The gain stage follows `gain_o` and freezes when `hold_o` is set. The sample path zeroes its output while `mute_o` is high. With the enable low, the gate is fully open and the audio passes unchanged. The hold time is counted in sample strobes. The default of 12000 is 250 ms at 48 kHz.

Top module: `noise_gate_ctrl`

## Requirements
- R1: After reset, and in any cycle with `gate_en_i` low, `gated_o`, `mute_o` and `hold_o` are 0 and `gain_o` is all ones (maximum gain). A low enable also clears the hold timer.
- R2: The level counts as quiet when it is strictly below T(code). T(code) = M[code mod 4] * 2^(code div 4) * 2^(SAMPLE_W-24), with M = {1255, 1492, 1773, 2107}. Code 0 is about -76.5 dBFS, and each code step raises T by about 1.5 dB.
- R3: On each valid sample, the level becomes the sample magnitude when that magnitude is at or above the current level. Otherwise the level drops by max(1, level >> DECAY_SHIFT). The most negative sample counts as magnitude 2^(SAMPLE_W-1)-1.
- R4: `gated_o` rises on the HOLD_SAMPLES-th consecutive valid sample that leaves the level quiet.
- R5: A valid sample that leaves the level at or above T clears `gated_o` and the timer on that same sample.
- R6: Type 2'b00 (hold): while gated, `hold_o` is 1, `mute_o` is 0 and `gain_o` stays at maximum.
- R7: Type 2'b01 (mute): while gated, `mute_o` is 1 and `gain_o` stays at maximum.
- R8: Type 2'b10 (fade): while gated, `gain_o` drops by one every FADE_DIV valid samples and stops at 0. The first step comes FADE_DIV samples after gating. `mute_o` stays 0.
- R9: Type 2'b11 (fade then mute): the gain ramps as in R8, and `mute_o` rises only once `gain_o` is 0.
- R10: Cycles with `sample_valid_i` low change neither the level, the timer nor the fade ramp.
- R11: `gain_o` returns to maximum as soon as the gate opens or the type code leaves the fade types.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Sample strobe, one per audio sample |
| sample_i | input | SAMPLE_W | Signed audio sample |
| gate_en_i | input | 1 | Gate enable |
| gate_type_i | input | 2 | Gate action: 00 hold, 01 mute, 10 fade, 11 fade then mute |
| gate_thr_i | input | 5 | Threshold code |
| gated_o | output | 1 | Gate is closed |
| hold_o | output | 1 | Freeze the gain stage |
| mute_o | output | 1 | Zero the sample path |
| gain_o | output | GAIN_W | Gain command, all ones is maximum |

## Verification
The level, the timer and the fade ramp all update on the clock edge that takes a valid sample. Every result of that sample is therefore visible straight after that edge, with no further delay. An enable or type change reaches the outputs in the same cycle, through combinational masking. The bench drives each sample at a falling edge and reads the outputs at the next falling edge, half a cycle after the capturing edge. Hand-worked vectors cover the threshold boundaries one below and at T, the decay of the level, the ramp steps and a run of idle cycles between samples.

// File: rtl/ng_pkg.sv
package ng_pkg;

  typedef enum logic [1:0] {
    GT_HOLD      = 2'b00,
    GT_MUTE      = 2'b01,
    GT_FADE      = 2'b10,
    GT_FADE_MUTE = 2'b11
  } gate_type_e;

  // 32-code threshold ROM: 4 mantissas (1.5 dB apart) times a 6 dB octave shift
  function automatic logic [31:0] thr_lin(input logic [4:0] code, input int unsigned sw);
    logic [31:0] m;
    case (code[1:0])
      2'd0:    m = 32'd1255;
      2'd1:    m = 32'd1492;
      2'd2:    m = 32'd1773;
      default: m = 32'd2107;
    endcase
    m = m << code[4:2];
    if (sw >= 24) return m << (sw - 24);
    else          return m >> (24 - sw);
  endfunction

endpackage

// File: rtl/ng_level.sv
module ng_level #(
  parameter int unsigned SAMPLE_W    = 24,
  parameter int unsigned DECAY_SHIFT = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [4:0]          thr_code_i,
  output logic                quiet_o
);
  localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic [SAMPLE_W-1:0] MAX_POS  = {1'b0, {(SAMPLE_W-1){1'b1}}};

  logic [SAMPLE_W-1:0] mag, dec, peak_q, peak_d;
  logic [31:0]         thr, peak_ext;

  always_comb begin
    if (!sample_i[SAMPLE_W-1])    mag = sample_i;
    else if (sample_i == MOST_NEG) mag = MAX_POS;
    else                           mag = (~sample_i) + 1'b1;
  end

  always_comb begin
    dec = peak_q >> DECAY_SHIFT;
    if (dec == '0) dec = {{(SAMPLE_W-1){1'b0}}, 1'b1};
    peak_d = (mag >= peak_q) ? mag : (peak_q - dec);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      peak_q <= '0;
    else if (valid_i) peak_q <= peak_d;
  end

  // quiet judged on the level after this sample, so a loud sample releases at once
  assign thr      = ng_pkg::thr_lin(thr_code_i, SAMPLE_W);
  assign peak_ext = 32'(peak_d);
  assign quiet_o  = peak_ext < thr;

endmodule

// File: rtl/ng_timer.sv
module ng_timer #(
  parameter int unsigned HOLD_SAMPLES = 12000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic valid_i,
  input  logic quiet_i,
  output logic gated_o
);
  localparam int unsigned CW = $clog2(HOLD_SAMPLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_SAMPLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i)           cnt_q <= '0;
    else if (valid_i) begin
      if (!quiet_i)           cnt_q <= '0;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign gated_o = en_i && (cnt_q == LIMIT);

endmodule

// File: rtl/ng_fade.sv
module ng_fade #(
  parameter int unsigned GAIN_W   = 6,
  parameter int unsigned FADE_DIV = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              active_i,
  output logic [GAIN_W-1:0] gain_o
);
  localparam int unsigned DW = (FADE_DIV > 1) ? $clog2(FADE_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(FADE_DIV - 1);
  localparam logic [GAIN_W-1:0] GAIN_MAX = '1;

  logic [GAIN_W-1:0] gain_q;
  logic [DW-1:0]     div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_q <= GAIN_MAX;
      div_q  <= '0;
    end else if (!active_i) begin
      gain_q <= GAIN_MAX;
      div_q  <= '0;
    end else if (valid_i && gain_q != '0) begin
      if (div_q == DIV_LAST) begin
        div_q  <= '0;
        gain_q <= gain_q - 1'b1;
      end else begin
        div_q  <= div_q + 1'b1;
      end
    end
  end

  // open gate restores full gain in the same cycle
  assign gain_o = active_i ? gain_q : GAIN_MAX;

endmodule

// File: rtl/noise_gate_ctrl.sv
module noise_gate_ctrl
  import ng_pkg::*;
#(
  parameter int unsigned SAMPLE_W     = 24,
  parameter int unsigned HOLD_SAMPLES = 12000,
  parameter int unsigned FADE_DIV     = 64,
  parameter int unsigned GAIN_W       = 6,
  parameter int unsigned DECAY_SHIFT  = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sample_valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                gate_en_i,
  input  logic [1:0]          gate_type_i,
  input  logic [4:0]          gate_thr_i,
  output logic                gated_o,
  output logic                hold_o,
  output logic                mute_o,
  output logic [GAIN_W-1:0]   gain_o
);
  gate_type_e typ;
  logic quiet, gated, fade_act;

  assign typ = gate_type_e'(gate_type_i);

  ng_level #(.SAMPLE_W(SAMPLE_W), .DECAY_SHIFT(DECAY_SHIFT)) u_level (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (sample_valid_i),
    .sample_i  (sample_i),
    .thr_code_i(gate_thr_i),
    .quiet_o   (quiet)
  );

  ng_timer #(.HOLD_SAMPLES(HOLD_SAMPLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (gate_en_i),
    .valid_i(sample_valid_i),
    .quiet_i(quiet),
    .gated_o(gated)
  );

  assign fade_act = gated && (typ == GT_FADE || typ == GT_FADE_MUTE);

  ng_fade #(.GAIN_W(GAIN_W), .FADE_DIV(FADE_DIV)) u_fade (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (sample_valid_i),
    .active_i(fade_act),
    .gain_o  (gain_o)
  );

  assign gated_o = gated;
  assign hold_o  = gated && (typ == GT_HOLD);
  assign mute_o  = gated && ((typ == GT_MUTE) || (typ == GT_FADE_MUTE && gain_o == '0));

endmodule

// File: rtl/ng_checker.sv
module ng_checker #(
  parameter int unsigned GAIN_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sample_valid_i,
  input logic              gate_en_i,
  input logic [1:0]        gate_type_i,
  input logic              gated_o,
  input logic              hold_o,
  input logic              mute_o,
  input logic [GAIN_W-1:0] gain_o
);
  localparam logic [GAIN_W-1:0] GMAX = '1;

  a_r1_disabled_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_en_i |-> (!gated_o && !mute_o && !hold_o && gain_o == GMAX));

  a_r4_close_on_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gated_o) |-> $past(sample_valid_i));

  a_r6_hold_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> (gated_o && gate_type_i == 2'b00 && !mute_o));

  a_r7_mute_needs_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_o |-> gated_o);

  a_r8_gain_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gated_o && $past(gated_o) && gate_type_i[1] && $past(gate_type_i[1]))
      |-> (gain_o <= $past(gain_o) && ($past(gain_o) - gain_o) <= 1));

  a_r9_mute_at_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mute_o && gate_type_i == 2'b11) |-> gain_o == '0);

  a_r10_idle_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(sample_valid_i) && $past(gate_en_i) && gate_en_i) |-> gated_o == $past(gated_o));

  a_r11_open_full_gain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gated_o |-> gain_o == GMAX);

endmodule

bind noise_gate_ctrl ng_checker #(.GAIN_W(GAIN_W)) u_ng_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sample_valid_i(sample_valid_i),
  .gate_en_i     (gate_en_i),
  .gate_type_i   (gate_type_i),
  .gated_o       (gated_o),
  .hold_o        (hold_o),
  .mute_o        (mute_o),
  .gain_o        (gain_o)
);

// File: tb/test_noise_gate_ctrl.sv
`timescale 1ns/1ps
module test_noise_gate_ctrl;
  localparam int SW = 24;
  localparam int GW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic [SW-1:0] smp = '0;
  logic          en = 1'b0;
  logic [1:0]    typ = 2'b00;
  logic [4:0]    thr = 5'd0;
  logic          gated, hold, mute;
  logic [GW-1:0] gain;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  noise_gate_ctrl #(.SAMPLE_W(SW), .HOLD_SAMPLES(4), .FADE_DIV(2), .GAIN_W(GW), .DECAY_SHIFT(1))
  i_noise_gate_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(valid), .sample_i(smp),
    .gate_en_i(en), .gate_type_i(typ), .gate_thr_i(thr),
    .gated_o(gated), .hold_o(hold), .mute_o(mute), .gain_o(gain)
  );

  typedef struct packed {
    logic        en;
    logic [1:0]  typ;
    logic [4:0]  thr;
    int          smp;
    int          n;
    logic        g, m, h;
    logic [1:0]  gain;
    int          req;
  } vec_t;

  // hold 4, fade div 2, decay shift 1, T(0)=1255, T(1)=1492, T(31)=269696
  localparam vec_t VEC [22] = '{
    '{1'b0, 2'd0,  5'd0,        0, 6, 1'b0, 1'b0, 1'b0, 2'd3,  1}, // R1
    '{1'b1, 2'd0,  5'd0,        0, 3, 1'b0, 1'b0, 1'b0, 2'd3,  4}, // R4 not yet
    '{1'b1, 2'd0,  5'd0,        0, 1, 1'b1, 1'b0, 1'b1, 2'd3,  6}, // R6
    '{1'b1, 2'd0,  5'd0,     1255, 1, 1'b0, 1'b0, 1'b0, 2'd3,  5}, // R5 at T
    '{1'b1, 2'd0,  5'd0,        0, 3, 1'b0, 1'b0, 1'b0, 2'd3,  3}, // R3 decay 628,314,157
    '{1'b1, 2'd0,  5'd0,        0, 1, 1'b1, 1'b0, 1'b1, 2'd3,  4}, // R4
    '{1'b1, 2'd1,  5'd0,        0, 1, 1'b1, 1'b1, 1'b0, 2'd3,  7}, // R7
    '{1'b1, 2'd2,  5'd0,        0, 1, 1'b1, 1'b0, 1'b0, 2'd3,  8}, // R8 first div
    '{1'b1, 2'd2,  5'd0,        0, 1, 1'b1, 1'b0, 1'b0, 2'd2,  8}, // R8 step
    '{1'b1, 2'd2,  5'd0,        0, 4, 1'b1, 1'b0, 1'b0, 2'd0,  8}, // R8 floor
    '{1'b1, 2'd3,  5'd0,        0, 1, 1'b1, 1'b1, 1'b0, 2'd0,  9}, // R9
    '{1'b1, 2'd3,  5'd0,     1254, 1, 1'b1, 1'b1, 1'b0, 2'd0,  2}, // R2 below T
    '{1'b1, 2'd3,  5'd1,        0, 1, 1'b1, 1'b1, 1'b0, 2'd0,  2}, // R2
    '{1'b1, 2'd3,  5'd1,     1500, 1, 1'b0, 1'b0, 1'b0, 2'd3, 11}, // R11 release
    '{1'b1, 2'd3,  5'd1,        0, 4, 1'b1, 1'b0, 1'b0, 2'd3,  4}, // R4
    '{1'b1, 2'd3,  5'd1,        0, 5, 1'b1, 1'b0, 1'b0, 2'd1,  9}, // R9 no mute yet
    '{1'b1, 2'd3,  5'd1,        0, 1, 1'b1, 1'b1, 1'b0, 2'd0,  9}, // R9 mute at min
    '{1'b0, 2'd3,  5'd1,        0, 1, 1'b0, 1'b0, 1'b0, 2'd3,  1}, // R1
    '{1'b1, 2'd1, 5'd31,   269695, 4, 1'b1, 1'b1, 1'b0, 2'd3,  2}, // R2 top code
    '{1'b1, 2'd1, 5'd31,   269696, 1, 1'b0, 1'b0, 1'b0, 2'd3,  5}, // R5
    '{1'b1, 2'd1, 5'd31,  -269695, 4, 1'b1, 1'b1, 1'b0, 2'd3,  3}, // R3 magnitude
    '{1'b1, 2'd1, 5'd31, -8388608, 1, 1'b0, 1'b0, 1'b0, 2'd3,  3}  // R3 most negative
  };

  task automatic chk(input int req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input int req, input logic g, input logic m, input logic h, input int gn);
    chk(req, "gated", int'(gated), int'(g));
    chk(req, "mute",  int'(mute),  int'(m));
    chk(req, "hold",  int'(hold),  int'(h));
    chk(req, "gain",  int'(gain),  gn);
  endtask

  // drive at negedge, captured at posedge, outputs read at following negedge
  task automatic feed(input int s, input int n);
    for (int k = 0; k < n; k++) begin
      smp   = SW'(s);
      valid = 1'b1;
      @(negedge clk);
    end
    valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_all(1, 1'b0, 1'b0, 1'b0, 3); // R1 reset state
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 22; i++) begin
      en  = VEC[i].en;
      typ = VEC[i].typ;
      thr = VEC[i].thr;
      feed(VEC[i].smp, VEC[i].n);
      chk_all(VEC[i].req, VEC[i].g, VEC[i].m, VEC[i].h, int'(VEC[i].gain));
    end

    // R10: idle cycles do not advance the timer
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    en = 1'b1; typ = 2'd1; thr = 5'd0;
    feed(0, 3);
    repeat (10) @(negedge clk);
    chk(10, "gated after idle", int'(gated), 0);
    feed(0, 1);
    chk(10, "gated on 4th sample", int'(gated), 1);
    chk(7, "mute", int'(mute), 1);

    // R1: asynchronous reset while gated
    rst_n = 1'b0;
    #1;
    chk_all(1, 1'b0, 1'b0, 1'b0, 3);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: enable drop masks a closed gate in the same cycle
    feed(0, 4);
    chk(4, "gated", int'(gated), 1);
    en = 1'b0;
    #1;
    chk(1, "gated when disabled", int'(gated), 0);
    chk(1, "mute when disabled", int'(mute), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule